// File: doc/BRIEF.md
# Word-Framed Serial Transmitter

This block turns a 22-bit parallel word into a serial stream with a forwarded bit clock line. A rising edge on the strobe input captures the word into a one-word holding register. The word then leaves as a 26-slot frame: 24 data slots followed by two marker slots. In the marker slots the clock line stays high while the data line falls. That combination appears nowhere else in the stream, so a receiver can find word edges from the lines alone.

The slot rate comes from a bit-rate enable, not from a second clock. When no word is waiting, idle slots carry a zero data bit and the clock line keeps toggling. A half-rate mode stretches every slot over two enable pulses, for systems where the reference runs far faster than the strobe. Each slot's values appear on the outputs one clock after the enable cycle that starts the slot.

Top module: `wser_tx`

## Requirements
- R1: While rst_ni is low, both ser_data_o and ser_clk_o are 0. A pending word and a frame in progress are discarded, so after release only idle slots appear until the next strobe.
- R2: A word is captured only on a rising edge of strobe_i. Changes on data_i while strobe_i stays high are ignored, and one high level produces exactly one frame.
- R3: Frame slot k (k = 1..20) carries data_i[k-1]. Slots 21 and 22 carry 0. Slot 23 carries data_i[20] and slot 24 carries data_i[21].
- R4: In frame slots 1..24, the clock line is high in even slots and low in odd slots. Slot 25 has data 1 with clock high. Slot 26 has data 0 with clock high.
- R5: A slot that carries no word has data 0, and its clock level is the inverse of the previous slot's clock level.
- R6: A word captured while a frame is being sent starts in the slot right after that frame's slot 26, with no idle slot between, so the two frames begin 26 slots apart.
- R7: Slots advance only in cycles where bit_en_i is high. While bit_en_i is low, both outputs hold their values.
- R8: With half_rate_i high, a slot advances on every second enable pulse counted since reset, and the first pulse does not advance it. With half_rate_i low, a slot advances on every enable pulse.
- R9: The clock line is high in two consecutive slots only inside slots 24..26 of a frame. A run of high clock slots never exceeds three.
- R10: The holding register keeps one word. A second strobe edge that arrives before the pending word starts sending replaces that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-rate enable; one slot step per pulse (two in half-rate mode) |
| half_rate_i | input | 1 | Selects half serial rate |
| strobe_i | input | 1 | Capture strobe; the word is taken on its rising edge |
| data_i | input | 22 | Parallel word |
| ser_data_o | output | 1 | Serial data line |
| ser_clk_o | output | 1 | Forwarded bit clock line |

## Verification
A wrong slot counter or shift register shows at the ports within one frame. The marker triple moves off its 26-slot grid, or a decoded word comes out with swapped or shifted bits. A lost or stuck pending flag shows as a missing, repeated or delayed frame at the next frame end: a back-to-back pair no longer starts 26 slots apart, or idle slots fill the gap. A wrong rate phase shows within a few cycles as the clock line toggling twice as often as expected, or outputs changing in a cycle with no enable. The bench rebuilds words from the recorded line values and compares them with the words it sent.

// File: rtl/wser_pkg.sv
package wser_pkg;

  typedef struct packed {
    logic clk;
    logic dat;
  } line_t;

  typedef enum logic [2:0] {
    SK_IDLE,
    SK_FIRST,
    SK_DATA,
    SK_MARK,
    SK_SPACE
  } slot_kind_e;

endpackage

// File: rtl/wser_rate_gen.sv
module wser_rate_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic half_rate_i,
  output logic tick_o
);

  logic ph_q;

  // phase counts every enable pulse so mode selection only gates it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= 1'b0;
    else if (bit_en_i) ph_q <= ~ph_q;
  end

  assign tick_o = bit_en_i && (!half_rate_i || ph_q);

endmodule

// File: rtl/wser_capture.sv
module wser_capture #(
  parameter int unsigned DATA_W   = 22,
  parameter int unsigned DIRECT_W = 20,
  parameter int unsigned SLOT_W   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [SLOT_W-1:0] word_o,
  output logic              pend_o
);

  localparam int unsigned EXTRA_W  = DATA_W - DIRECT_W;
  localparam int unsigned TOP_BASE = SLOT_W - EXTRA_W;

  logic              stb_q;
  logic              pend_q;
  logic              rise;
  logic [SLOT_W-1:0] hold_q;
  logic [SLOT_W-1:0] mapped;

  // slot mapping: low bits direct, extra bits in the top slots, gap padded with zero
  for (genvar g = 0; g < SLOT_W; g++) begin : g_map
    if (g < DIRECT_W) begin : g_low
      assign mapped[g] = data_i[g];
    end else if (g >= TOP_BASE) begin : g_top
      assign mapped[g] = data_i[DIRECT_W + g - TOP_BASE];
    end else begin : g_pad
      assign mapped[g] = 1'b0;
    end
  end

  assign rise = strobe_i && !stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      stb_q <= strobe_i;
      if (rise) begin
        hold_q <= mapped;
        pend_q <= 1'b1;
      end else if (take_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign word_o = hold_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/wser_framer.sv
module wser_framer
  import wser_pkg::*;
#(
  parameter int unsigned SLOT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pend_i,
  input  logic [SLOT_W-1:0] word_i,
  output logic              take_o,
  output logic              free_o,
  output logic              ser_data_o,
  output logic              ser_clk_o
);

  localparam int unsigned FRAME_SLOTS = SLOT_W + 2;
  localparam int unsigned CNT_W       = $clog2(FRAME_SLOTS + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(SLOT_W);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_SLOTS);

  logic              active_q;
  logic [CNT_W-1:0]  slot_q;
  logic [SLOT_W-1:0] sr_q;
  line_t             line_q, line_d;
  slot_kind_e        kind;

  assign free_o = !active_q || (slot_q == LAST_SLOT);
  assign take_o = tick_i && free_o && pend_i;

  // kind of the slot that the next tick starts
  always_comb begin
    if (free_o)                 kind = pend_i ? SK_FIRST : SK_IDLE;
    else if (slot_q < LAST_DATA) kind = SK_DATA;
    else if (slot_q == LAST_DATA) kind = SK_MARK;
    else                        kind = SK_SPACE;
  end

  always_comb begin
    line_d = line_q;
    unique case (kind)
      SK_IDLE:  begin line_d.dat = 1'b0;      line_d.clk = ~line_q.clk; end
      SK_FIRST: begin line_d.dat = word_i[0]; line_d.clk = 1'b0;        end
      SK_DATA:  begin line_d.dat = sr_q[0];   line_d.clk = slot_q[0];   end
      SK_MARK:  begin line_d.dat = 1'b1;      line_d.clk = 1'b1;        end
      SK_SPACE: begin line_d.dat = 1'b0;      line_d.clk = 1'b1;        end
      default:  line_d = line_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      sr_q     <= '0;
      line_q   <= '0;
    end else if (tick_i) begin
      line_q <= line_d;
      unique case (kind)
        SK_IDLE: begin
          active_q <= 1'b0;
          slot_q   <= '0;
        end
        SK_FIRST: begin
          active_q <= 1'b1;
          slot_q   <= CNT_W'(1);
          sr_q     <= word_i >> 1;
        end
        SK_DATA: begin
          slot_q <= slot_q + CNT_W'(1);
          sr_q   <= sr_q >> 1;
        end
        default: slot_q <= slot_q + CNT_W'(1);
      endcase
    end
  end

  assign ser_data_o = line_q.dat;
  assign ser_clk_o  = line_q.clk;

endmodule

// File: rtl/wser_tx.sv
module wser_tx #(
  parameter int unsigned DATA_W   = 22,
  parameter int unsigned DIRECT_W = 20,
  parameter int unsigned SLOT_W   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              half_rate_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ser_data_o,
  output logic              ser_clk_o
);

  logic              tick;
  logic              take;
  logic              pend;
  logic              free;
  logic [SLOT_W-1:0] word;

  wser_rate_gen u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .half_rate_i(half_rate_i),
    .tick_o     (tick)
  );

  wser_capture #(
    .DATA_W  (DATA_W),
    .DIRECT_W(DIRECT_W),
    .SLOT_W  (SLOT_W)
  ) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .data_i  (data_i),
    .take_i  (take),
    .word_o  (word),
    .pend_o  (pend)
  );

  wser_framer #(
    .SLOT_W(SLOT_W)
  ) u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .pend_i    (pend),
    .word_i    (word),
    .take_o    (take),
    .free_o    (free),
    .ser_data_o(ser_data_o),
    .ser_clk_o (ser_clk_o)
  );

endmodule

// File: rtl/wser_tx_chk.sv
module wser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic ser_data_o,
  input logic ser_clk_o,
  input logic tick_i,
  input logic take_i,
  input logic pend_i,
  input logic free_i
);

  logic       tick_q;
  logic [1:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      hi_run <= '0;
    end else begin
      tick_q <= tick_i;
      if (tick_q) hi_run <= ser_clk_o ? ((hi_run == 2'd3) ? 2'd3 : hi_run + 2'd1) : 2'd0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!ser_data_o && !ser_clk_o));

  assert_frame_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !ser_clk_o);

  assert_idle_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && free_i && !pend_i) |=> (!ser_data_o && (ser_clk_o != $past(ser_clk_o))));

  assert_hold_no_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(ser_data_o) && $stable(ser_clk_o)));

  assert_high_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run != 2'd3 || !(tick_q && ser_clk_o));

endmodule

bind wser_tx wser_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_en_i  (bit_en_i),
  .ser_data_o(ser_data_o),
  .ser_clk_o (ser_clk_o),
  .tick_i    (tick),
  .take_i    (take),
  .pend_i    (pend),
  .free_i    (free)
);

// File: tb/tb_wser_tx.sv
module tb_wser_tx;

  localparam int CLK_P = 10;
  localparam int LOG_N = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        half = 1'b0;
  logic        strobe = 1'b0;
  logic [21:0] data = '0;
  logic        ser_d, ser_c;

  int checks = 0;
  int errors = 0;
  int en_pct = 100;
  int tick_total = 0;
  bit tick_seen = 0;
  bit ph = 0;

  bit lc [LOG_N];
  bit ld [LOG_N];
  bit cov [LOG_N];
  bit inb [LOG_N];
  int n_log = 0;

  logic [21:0] exp_w [64];
  int          n_exp;
  logic [21:0] dec_w [64];
  int          dec_b [64];
  int          n_dec;
  int pad_err, clk_err, mark_err, run_err, idle_err;

  wser_tx dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bit_en_i   (bit_en),
    .half_rate_i(half),
    .strobe_i   (strobe),
    .data_i     (data),
    .ser_data_o (ser_d),
    .ser_clk_o  (ser_c)
  );

  always #(CLK_P/2) clk = ~clk;

  // slot timing model from R7/R8
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0;
      tick_seen = 0;
    end else begin
      tick_seen = bit_en && (!half || ph);
      if (bit_en) ph = ~ph;
    end
  end

  always @(negedge clk) begin
    if (tick_seen && rst_n) begin
      if (n_log < LOG_N) begin
        lc[n_log] = ser_c;
        ld[n_log] = ser_d;
        n_log++;
      end
      tick_total++;
      tick_seen = 0;
    end
    bit_en = (int'($urandom % 100) < en_pct);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit h);
    @(negedge clk);
    rst_n = 1'b0;
    half = h;
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    n_log = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_ticks(input int n);
    int t0 = tick_total;
    while (tick_total < t0 + n) @(negedge clk);
  endtask

  task automatic pulse(input logic [21:0] w);
    @(negedge clk);
    data = w;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic push_exp(input logic [21:0] w);
    exp_w[n_exp] = w;
    n_exp++;
  endtask

  // receiver built from R3/R4/R5/R9
  task automatic decode();
    n_dec = 0; pad_err = 0; clk_err = 0; mark_err = 0; run_err = 0; idle_err = 0;
    for (int i = 0; i < n_log; i++) begin cov[i] = 0; inb[i] = 0; end
    for (int i = 25; i < n_log; i++) begin
      if (lc[i-2] && lc[i-1] && lc[i]) begin
        logic [21:0] w;
        w = '0;
        for (int k = 1; k <= 24; k++) begin
          int idx;
          idx = i - 26 + k;
          if (lc[idx] != (k % 2 == 0)) clk_err++;
          if (k <= 20) w[k-1] = ld[idx];
          else if (k <= 22) begin if (ld[idx]) pad_err++; end
          else w[k-3] = ld[idx];
        end
        if (!ld[i-1] || ld[i]) mark_err++;
        for (int j = i - 25; j <= i; j++) cov[j] = 1;
        for (int j = i - 2; j <= i; j++) inb[j] = 1;
        if (n_dec < 64) begin
          dec_w[n_dec] = w;
          dec_b[n_dec] = i;
          n_dec++;
        end
      end
    end
    for (int j = 1; j < n_log; j++) begin
      if (lc[j-1] && lc[j] && !(inb[j-1] && inb[j])) run_err++;
      if (!cov[j] && (ld[j] || lc[j] == lc[j-1])) idle_err++;
    end
  endtask

  task automatic verify(input string name);
    decode();
    chk(n_dec == n_exp, {name, " R3 frame count"}, n_dec, n_exp);
    for (int i = 0; i < n_exp && i < n_dec; i++)
      chk(dec_w[i] == exp_w[i], {name, " R3 word"}, dec_w[i], exp_w[i]);
    chk(pad_err == 0, {name, " R3 pad slots"}, pad_err, 0);
    chk(clk_err == 0, {name, " R4 data slot clock"}, clk_err, 0);
    chk(mark_err == 0, {name, " R4 marker"}, mark_err, 0);
    chk(run_err == 0, {name, " R9 high run"}, run_err, 0);
    chk(idle_err == 0, {name, " R5 idle fill"}, idle_err, 0);
  endtask

  task automatic count_toggles(output int tog);
    logic prev;
    tog = 0;
    @(negedge clk);
    prev = ser_c;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ser_c != prev) tog++;
      prev = ser_c;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tog;
    logic sd, sc;
    int bad;
    void'($urandom(32'd7331));

    // R1 reset state
    repeat (2) @(negedge clk);
    chk(!ser_d && !ser_c, "R1 reset lines", {ser_c, ser_d}, 0);

    // R5/R8 full-rate idle toggling
    do_reset(0);
    en_pct = 100;
    repeat (4) @(negedge clk);
    count_toggles(tog);
    chk(tog == 20, "R5 full-rate idle toggles", tog, 20);

    // R8 half-rate idle toggling
    do_reset(1);
    repeat (4) @(negedge clk);
    count_toggles(tog);
    chk(tog == 10, "R8 half-rate idle toggles", tog, 10);

    // R3 directed corner words
    do_reset(0);
    n_exp = 0;
    wait_ticks(3);
    pulse(22'h3FFFFF); push_exp(22'h3FFFFF); wait_ticks(30);
    pulse(22'h000001); push_exp(22'h000001); wait_ticks(30);
    pulse(22'h200000); push_exp(22'h200000); wait_ticks(30);
    pulse(22'h100000); push_exp(22'h100000); wait_ticks(30);
    pulse(22'h000000); push_exp(22'h000000); wait_ticks(40);
    verify("corner");

    // R6 back-to-back frames
    do_reset(0);
    n_exp = 0;
    wait_ticks(5);
    pulse(22'h2AAAAA); push_exp(22'h2AAAAA);
    wait_ticks(4);
    pulse(22'h155555); push_exp(22'h155555);
    wait_ticks(80);
    verify("b2b");
    chk(n_dec == 2 && dec_b[1] - dec_b[0] == 26, "R6 frame spacing",
        dec_b[1] - dec_b[0], 26);

    // R10 pending word replaced
    do_reset(0);
    n_exp = 0;
    wait_ticks(5);
    pulse(22'h0ABCDE); push_exp(22'h0ABCDE);
    wait_ticks(3);
    pulse(22'h123456);
    repeat (2) @(negedge clk);
    pulse(22'h3C3C3C); push_exp(22'h3C3C3C);
    wait_ticks(80);
    verify("R10 overwrite");

    // R2 strobe held high, data changing underneath
    do_reset(0);
    n_exp = 0;
    wait_ticks(3);
    @(negedge clk);
    data = 22'h0F0F0F;
    strobe = 1'b1;
    repeat (10) @(negedge clk);
    data = 22'h30F0F0;
    repeat (40) @(negedge clk);
    strobe = 1'b0;
    push_exp(22'h0F0F0F);
    wait_ticks(60);
    verify("R2 held strobe");

    // R7 enable gap mid-frame
    do_reset(0);
    n_exp = 0;
    wait_ticks(4);
    pulse(22'h2D2D2D); push_exp(22'h2D2D2D);
    wait_ticks(6);
    en_pct = 0;
    repeat (2) @(negedge clk);
    sd = ser_d; sc = ser_c;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ser_d != sd || ser_c != sc) bad++;
    end
    chk(bad == 0, "R7 hold without enable", bad, 0);
    en_pct = 100;
    wait_ticks(60);
    verify("R7 gap");

    // R1 reset mid-frame drops the word
    do_reset(0);
    wait_ticks(4);
    pulse(22'h3FFFFF);
    wait_ticks(8);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ser_d && !ser_c, "R1 lines in reset", {ser_c, ser_d}, 0);
    @(negedge clk);
    n_log = 0;
    rst_n = 1'b1;
    n_exp = 0;
    wait_ticks(80);
    verify("R1 after reset");

    // random words, random enable, full rate
    do_reset(0);
    en_pct = 70;
    n_exp = 0;
    wait_ticks(3);
    for (int i = 0; i < 16; i++) begin
      logic [21:0] w;
      w = 22'($urandom);
      pulse(w);
      push_exp(w);
      wait_ticks(30);
    end
    wait_ticks(40);
    verify("random full");

    // random words, half rate (R8)
    do_reset(1);
    en_pct = 80;
    n_exp = 0;
    wait_ticks(3);
    for (int i = 0; i < 5; i++) begin
      logic [21:0] w;
      w = 22'($urandom);
      pulse(w);
      push_exp(w);
      wait_ticks(30);
    end
    wait_ticks(40);
    verify("R8 half random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule